// File: doc/BRIEF.md
# Single-to-BFloat16 Narrowing Converter

This block takes one IEEE-754 single-precision operand and narrows it to the 16-bit brain-float format. The 16-bit result goes into the upper half of a 32-bit destination word, and the destination's lower half passes through untouched. The conversion follows the live control settings: one of four rounding directions, flush-to-zero of subnormal inputs, and substitution of a canonical NaN for any NaN result.

Each exception the conversion raises is handled by its own enable bit. With the enable clear, the exception is accumulated into a sticky flag register. With the enable set, the block raises a trap request for the cycle instead. A condition input can cancel an operation. A cancelled operation leaves the destination, the sticky flags and the trap request exactly as they were.

All results are registered. They appear one clock after the operation is presented with `inValid` high.

Top module: `bf16_narrow_unit`

## Requirements
- R1: One cycle after an accepted operation (`inValid` and `condPass` both high), `resWord[31:16]` holds the converted value and `resWord[15:0]` equals the `dstKeep` value presented with it.
- R2: Rounding acts on the 16 discarded low bits. The `rndMode` encoding is 0 = nearest with ties to even, 1 = toward +infinity, 2 = toward -infinity, 3 = toward zero.
- R3: With `ftzEn` high, a subnormal input gives a zero of the same sign and raises only input-denormal.
- R4: A signalling NaN raises invalid-operation, and a quiet NaN raises nothing. With `dnanEn` high, every NaN result is 0x7FC0. Otherwise the result keeps the sign and the upper six payload bits and forces the quiet bit. Infinities convert exactly.
- R5: When rounding carries the exponent up to all ones, the result is a signed infinity and both overflow and inexact are raised.
- R6: Any nonzero discarded bit raises inexact. An exactly representable finite input raises no exception.
- R7: With `ftzEn` low, an inexact conversion of a subnormal input raises underflow together with inexact.
- R8: The flag bit positions are 0 invalid, 1 overflow, 2 underflow, 3 inexact, 4 input-denormal. A raised exception whose `trapEn` bit is clear is ORed into `flags`. `flags` never clears except on reset.
- R9: If any raised exception has its `trapEn` bit set, `trapReq` is high for the cycle after the operation, and the matching flag bit is not set.
- R10: With `condPass` low, `resWord` and `flags` stay unchanged and `trapReq` stays low.
- R11: `outValid` follows `inValid` one cycle later. Reset clears `resWord`, `flags`, `trapReq` and `outValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operation presented this cycle |
| condPass | input | 1 | Condition passed; low cancels the operation |
| srcWord | input | 32 | Single-precision source operand |
| dstKeep | input | 16 | Current lower half of the destination |
| rndMode | input | 2 | Rounding direction |
| ftzEn | input | 1 | Flush subnormal inputs to zero |
| dnanEn | input | 1 | Replace NaN results with the canonical NaN |
| trapEn | input | 5 | Per-exception trap enables |
| outValid | output | 1 | Result registered this cycle |
| resWord | output | 32 | Merged destination word |
| flags | output | 5 | Sticky exception flags |
| trapReq | output | 1 | Synchronous trap request |

## Verification
The block has no size parameters: the formats are fixed in the package, so the bench builds the top as it is. The vector table sweeps all four rounding directions across the following cases:
- ties that round to even
- one-ulp increments on both signs
- the largest finite value, which either saturates or carries into infinity depending on direction
- signed zeros and infinities
- both kinds of NaN, with and without default-NaN
- subnormals, with flush-to-zero on and off

Directed tests cover cancellation, reset, and the split between trapped and accumulated exceptions, including an overflow whose inexact half is trapped.

// File: rtl/bf16_cvt_pkg.sv
package bf16_cvt_pkg;
  localparam int SP_W   = 32;
  localparam int BF_W   = 16;
  localparam int DROP_W = SP_W - BF_W;
  localparam int EXP_W  = 8;
  localparam int FLAG_W = 5;

  localparam int FLG_INV = 0;
  localparam int FLG_OVF = 1;
  localparam int FLG_UNF = 2;
  localparam int FLG_INX = 3;
  localparam int FLG_IDN = 4;

  localparam logic [BF_W-1:0] CANON_NAN = 16'h7FC0;

  typedef enum logic [1:0] {
    RND_NEAREST = 2'd0,
    RND_POS     = 2'd1,
    RND_NEG     = 2'd2,
    RND_ZERO    = 2'd3
  } rnd_mode_t;

  typedef struct packed {
    logic capture;
    logic quietTrap;
  } ctl_strobe_t;
endpackage

// File: rtl/bf16_cvt_dp.sv
module bf16_cvt_dp
  import bf16_cvt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  ctl_strobe_t         strobe,
  input  logic [SP_W-1:0]     srcWord,
  input  logic [DROP_W-1:0]   dstKeep,
  input  logic [1:0]          rndMode,
  input  logic                ftzEn,
  input  logic                dnanEn,
  output logic [FLAG_W-1:0]   raised,
  output logic [SP_W-1:0]     resWord
);
  localparam int KEEP_W = SP_W - 1 - DROP_W;
  localparam int MAN_W  = SP_W - 1 - EXP_W;

  logic              sgn;
  logic [EXP_W-1:0]  expF;
  logic [MAN_W-1:0]  manF;
  logic              isNan, isSnan, isInf, isSub;
  logic [KEEP_W-1:0] keepBits, sumBits;
  logic [DROP_W-1:0] dropBits;
  logic              guardB, stickyB, lostAny, incr;
  logic [BF_W-1:0]   bfRes;
  rnd_mode_t         mode;

  assign sgn      = srcWord[SP_W-1];
  assign expF     = srcWord[SP_W-2 -: EXP_W];
  assign manF     = srcWord[MAN_W-1:0];
  assign isNan    = (expF == '1) && (manF != '0);
  assign isSnan   = isNan && !manF[MAN_W-1];
  assign isInf    = (expF == '1) && (manF == '0);
  assign isSub    = (expF == '0) && (manF != '0);
  assign keepBits = srcWord[SP_W-2:DROP_W];
  assign dropBits = srcWord[DROP_W-1:0];
  assign guardB   = dropBits[DROP_W-1];
  assign stickyB  = |dropBits[DROP_W-2:0];
  assign lostAny  = guardB | stickyB;
  assign mode     = rnd_mode_t'(rndMode);

  always_comb begin
    case (mode)
      RND_NEAREST: incr = guardB && (stickyB || keepBits[0]);
      RND_POS:     incr = !sgn && lostAny;
      RND_NEG:     incr = sgn && lostAny;
      default:     incr = 1'b0;
    endcase
  end

  assign sumBits = keepBits + KEEP_W'(incr);

  always_comb begin
    raised = '0;
    bfRes  = {sgn, sumBits};
    if (isNan) begin
      raised[FLG_INV] = isSnan;
      bfRes = dnanEn ? CANON_NAN
                     : {sgn, {EXP_W{1'b1}}, 1'b1, manF[MAN_W-2 -: (BF_W-EXP_W-2)]};
    end else if (isInf) begin
      bfRes = {sgn, {EXP_W{1'b1}}, {(BF_W-1-EXP_W){1'b0}}};
    end else if (isSub && ftzEn) begin
      bfRes = {sgn, {(BF_W-1){1'b0}}};
      raised[FLG_IDN] = 1'b1;
    end else begin
      raised[FLG_INX] = lostAny;
      raised[FLG_OVF] = (sumBits[KEEP_W-1 -: EXP_W] == '1);
      raised[FLG_UNF] = isSub && lostAny;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      resWord <= '0;
    else if (strobe.capture)
      resWord <= {bfRes, dstKeep};
  end
endmodule

// File: rtl/bf16_cvt_ctl.sv
module bf16_cvt_ctl
  import bf16_cvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              condPass,
  input  logic [FLAG_W-1:0] raised,
  input  logic [FLAG_W-1:0] trapEn,
  output ctl_strobe_t       strobe,
  output logic              outValid,
  output logic [FLAG_W-1:0] flags,
  output logic              trapReq
);
  logic [FLAG_W-1:0] trapped, accrued;

  assign strobe.capture   = inValid && condPass;
  assign trapped          = raised & trapEn;
  assign accrued          = raised & ~trapEn;
  assign strobe.quietTrap = (trapped == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      trapReq  <= 1'b0;
      flags    <= '0;
    end else begin
      outValid <= inValid;
      trapReq  <= strobe.capture && !strobe.quietTrap;
      if (strobe.capture)
        flags <= flags | accrued;
    end
  end
endmodule

// File: rtl/bf16_narrow_unit.sv
module bf16_narrow_unit
  import bf16_cvt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inValid,
  input  logic              condPass,
  input  logic [SP_W-1:0]   srcWord,
  input  logic [DROP_W-1:0] dstKeep,
  input  logic [1:0]        rndMode,
  input  logic              ftzEn,
  input  logic              dnanEn,
  input  logic [FLAG_W-1:0] trapEn,
  output logic              outValid,
  output logic [SP_W-1:0]   resWord,
  output logic [FLAG_W-1:0] flags,
  output logic              trapReq
);
  ctl_strobe_t       strobe;
  logic [FLAG_W-1:0] raised;

  bf16_cvt_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .inValid  (inValid),
    .condPass (condPass),
    .raised   (raised),
    .trapEn   (trapEn),
    .strobe   (strobe),
    .outValid (outValid),
    .flags    (flags),
    .trapReq  (trapReq)
  );

  bf16_cvt_dp u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (strobe),
    .srcWord (srcWord),
    .dstKeep (dstKeep),
    .rndMode (rndMode),
    .ftzEn   (ftzEn),
    .dnanEn  (dnanEn),
    .raised  (raised),
    .resWord (resWord)
  );
endmodule

// File: rtl/bf16_narrow_unit_chk.sv
module bf16_narrow_unit_chk
  import bf16_cvt_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic              condPass,
  input logic [SP_W-1:0]   srcWord,
  input logic [DROP_W-1:0] dstKeep,
  input logic              ftzEn,
  input logic              dnanEn,
  input logic              outValid,
  input logic [SP_W-1:0]   resWord,
  input logic [FLAG_W-1:0] flags,
  input logic              trapReq
);
  logic srcSub, srcNan;
  assign srcSub = (srcWord[30:23] == 8'h00) && (srcWord[22:0] != '0);
  assign srcNan = (srcWord[30:23] == 8'hFF) && (srcWord[22:0] != '0);

  AST_LOW_HALF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && condPass |=> resWord[DROP_W-1:0] == $past(dstKeep)); // R1
  AST_FTZ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && condPass && ftzEn && srcSub |=> resWord[30:16] == '0); // R3
  AST_DEFAULT_NAN: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && condPass && dnanEn && srcNan |=> resWord[31:16] == CANON_NAN); // R4
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (flags & $past(flags)) == $past(flags)); // R8
  AST_FLAG_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    flags != $past(flags) |-> $past(inValid && condPass)); // R8
  AST_TRAP_NEEDS_OP: assert property (@(posedge clk) disable iff (!rst_n)
    trapReq |-> $past(inValid && condPass)); // R9
  AST_CANCEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !condPass |=> $stable(resWord) && $stable(flags) && !trapReq); // R10
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> outValid == $past(inValid)); // R11
endmodule

bind bf16_narrow_unit bf16_narrow_unit_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .condPass (condPass),
  .srcWord  (srcWord),
  .dstKeep  (dstKeep),
  .ftzEn    (ftzEn),
  .dnanEn   (dnanEn),
  .outValid (outValid),
  .resWord  (resWord),
  .flags    (flags),
  .trapReq  (trapReq)
);

// File: tb/bf16_narrow_unit_tb.sv
`timescale 1ns/1ps
module bf16_narrow_unit_tb;
  localparam int NV = 23;
  // {src[56:25], rnd[24:23], ftz[22], dnan[21], expected bf16[20:5], raised flags[4:0]}
  localparam logic [56:0] VECS [0:NV-1] = '{
    {32'h3F800000, 2'd0, 1'b0, 1'b0, 16'h3F80, 5'h00}, // R6 exact
    {32'h3F808000, 2'd0, 1'b0, 1'b0, 16'h3F80, 5'h08}, // R2 tie to even, stays
    {32'h3F818000, 2'd0, 1'b0, 1'b0, 16'h3F82, 5'h08}, // R2 tie to even, up
    {32'h3F808001, 2'd0, 1'b0, 1'b0, 16'h3F81, 5'h08}, // R2 above half
    {32'h3F800001, 2'd1, 1'b0, 1'b0, 16'h3F81, 5'h08}, // R2 +inf dir
    {32'hBF800001, 2'd1, 1'b0, 1'b0, 16'hBF80, 5'h08}, // R2 +inf dir, negative
    {32'hBF800001, 2'd2, 1'b0, 1'b0, 16'hBF81, 5'h08}, // R2 -inf dir
    {32'h3F80FFFF, 2'd3, 1'b0, 1'b0, 16'h3F80, 5'h08}, // R2 toward zero
    {32'h7F7FFFFF, 2'd0, 1'b0, 1'b0, 16'h7F80, 5'h0A}, // R5
    {32'h7F7FFFFF, 2'd3, 1'b0, 1'b0, 16'h7F7F, 5'h08}, // R5 no carry
    {32'hFF7FFFFF, 2'd1, 1'b0, 1'b0, 16'hFF7F, 5'h08}, // R5 no carry
    {32'hFF7FFFFF, 2'd2, 1'b0, 1'b0, 16'hFF80, 5'h0A}, // R5
    {32'h7F800000, 2'd0, 1'b0, 1'b0, 16'h7F80, 5'h00}, // R4 infinity
    {32'hFF800000, 2'd1, 1'b0, 1'b0, 16'hFF80, 5'h00}, // R4 infinity
    {32'h80000000, 2'd2, 1'b0, 1'b0, 16'h8000, 5'h00}, // R6 negative zero
    {32'hFF812345, 2'd0, 1'b0, 1'b0, 16'hFFC1, 5'h01}, // R4 signalling NaN
    {32'hFF812345, 2'd0, 1'b0, 1'b1, 16'h7FC0, 5'h01}, // R4 default NaN
    {32'h7FC12345, 2'd0, 1'b0, 1'b0, 16'h7FC1, 5'h00}, // R4 quiet NaN
    {32'h00012345, 2'd0, 1'b1, 1'b0, 16'h0000, 5'h10}, // R3
    {32'h80400000, 2'd1, 1'b1, 1'b0, 16'h8000, 5'h10}, // R3
    {32'h00012345, 2'd0, 1'b0, 1'b0, 16'h0001, 5'h0C}, // R7
    {32'h00400000, 2'd0, 1'b0, 1'b0, 16'h0040, 5'h00}, // R7 exact subnormal
    {32'h007FFFFF, 2'd0, 1'b0, 1'b0, 16'h0080, 5'h0C}  // R7 rounds up
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inValid = 1'b0, condPass = 1'b0, ftzEn = 1'b0, dnanEn = 1'b0;
  logic [31:0] srcWord = '0;
  logic [15:0] dstKeep = '0;
  logic [1:0]  rndMode = '0;
  logic [4:0]  trapEn = '0;
  logic        outValid, trapReq;
  logic [31:0] resWord;
  logic [4:0]  flags;
  int          nRun = 0, nFail = 0;
  logic [4:0]  expFlags;
  logic [31:0] heldRes;

  always #4 clk = ~clk;

  bf16_narrow_unit u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .condPass(condPass),
    .srcWord(srcWord), .dstKeep(dstKeep), .rndMode(rndMode), .ftzEn(ftzEn),
    .dnanEn(dnanEn), .trapEn(trapEn), .outValid(outValid), .resWord(resWord),
    .flags(flags), .trapReq(trapReq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] s, input logic [1:0] rm, input logic fz,
                       input logic dn, input logic [15:0] lo, input logic cp);
    @(negedge clk);
    srcWord = s; rndMode = rm; ftzEn = fz; dnanEn = dn; dstKeep = lo;
    condPass = cp; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; condPass = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R11 reset resWord", resWord, 32'h0);
    check("R11 reset flags", {27'h0, flags}, 32'h0);
    check("R11 reset trapReq/outValid", {30'h0, trapReq, outValid}, 32'h0);
    rst_n = 1'b1;

    expFlags = '0;
    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      logic [15:0] lo;
      string tag;
      v = VECS[i];
      lo = 16'hA5A5 ^ 16'(i * 16'h0101);
      issue(v[56:25], v[24:23], v[22], v[21], lo, 1'b1);
      if (v[0] || v[20:13] == 8'hFF) tag = "R4";
      else if (v[4]) tag = "R3";
      else if (v[1]) tag = "R5";
      else if (v[2]) tag = "R7";
      else tag = "R2";
      check($sformatf("%s/R1 vector %0d result", tag, i), resWord, {v[20:5], lo});
      expFlags = expFlags | v[4:0];
      check($sformatf("R8/R6 vector %0d sticky flags", i), {27'h0, flags}, {27'h0, expFlags});
      check($sformatf("R11 vector %0d outValid, no trap", i), {30'h0, outValid, trapReq}, 32'h2);
    end

    // R10: cancelled op changes nothing
    heldRes = resWord;
    issue(32'hFF812345, 2'd0, 1'b0, 1'b0, 16'h1234, 1'b0);
    check("R10 cancel resWord", resWord, heldRes);
    check("R10 cancel flags", {27'h0, flags}, {27'h0, expFlags});
    check("R10 cancel trapReq", {31'h0, trapReq}, 32'h0);

    // R11: idle cycle drops outValid
    @(negedge clk);
    check("R11 idle outValid", {31'h0, outValid}, 32'h0);

    doReset();
    check("R11 second reset flags", {27'h0, flags}, 32'h0);

    // R9: inexact trapped
    trapEn = 5'b01000;
    issue(32'h3F808001, 2'd0, 1'b0, 1'b0, 16'h5555, 1'b1);
    check("R9 trap on inexact", {31'h0, trapReq}, 32'h1);
    check("R9 trapped flag not set", {27'h0, flags}, 32'h0);
    check("R1 trapped op still writes", resWord, 32'h3F815555);
    // R9/R8: overflow accrues while its inexact traps
    issue(32'h7F7FFFFF, 2'd0, 1'b0, 1'b0, 16'h0F0F, 1'b1);
    check("R9 trap on overflow op", {31'h0, trapReq}, 32'h1);
    check("R8 overflow accrues alone", {27'h0, flags}, 32'h02);
    // R9: exact op raises nothing
    issue(32'h3F800000, 2'd0, 1'b0, 1'b0, 16'h0000, 1'b1);
    check("R9 no trap when exact", {31'h0, trapReq}, 32'h0);
    // R9: trap lasts one cycle
    @(negedge clk);
    check("R9 trap one cycle", {31'h0, trapReq}, 32'h0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule